// File: doc/BRIEF.md
# Sequential Unsigned Shift-Add Multiplier

This block multiplies two unsigned operands, 32 bits each by default, into a double-width product. It uses one adder and one accumulator register, and it runs over many clock cycles rather than in a single wide array. A host controller drives the single `start` level. That level is the logical OR of the system reset and a clear pulse from the controller. While `start` is high, the unit sits in its initialise state.

On the first rising clock edge at which `start` is low, the unit captures both operands. It then performs one conditional add followed by a right shift per clock, for as many iterations as the operand width. After the last iteration it raises `done_o`. It holds the upper half of the product on `hi_o` and the lower half on `lo_o` until `start` is raised again. The host waits for `done_o` before it copies the two halves into its own high and low result registers.

The working registers are loaded when the unit leaves the initialise state, not when it enters it. Raising `start` therefore resets only the sequencing. The product halves keep their stale contents until the next run loads them.

Top module: `smul_top`

## Requirements
- R1: While `start` is high, `done_o` is low. Raising `start` at any time, including in the middle of a run, forces `done_o` low immediately.
- R2: The operands are captured at the first rising edge at which `start` is low. Any change to `mcand_i` or `mplier_i` after that edge has no effect on the result of that run.
- R3: Count the capturing edge as edge 0. `done_o` is still low after edge WIDTH-1 (31) and is high after edge WIDTH (32). Exactly WIDTH add-and-shift iterations take place.
- R4: When `done_o` is high, `{hi_o, lo_o}` equals the full unsigned product of the captured operands, with no truncation.
- R5: Multiplying by zero gives 0. All-ones times all-ones gives 0xFFFFFFFE_00000001. All-ones times 1 gives 0x00000000_FFFFFFFF.
- R6: Once `done_o` is high, it stays high and `hi_o`/`lo_o` stay stable for as long as `start` stays low.
- R7: A run abandoned by raising `start` mid-run has no effect on the next run, which produces the correct product.
- R8: `hi_o` carries product bits 2*WIDTH-1..WIDTH (63:32) and `lo_o` carries bits WIDTH-1..0 (31:0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| start | input | 1 | Level-held restart, active high; asynchronously forces the initialise state |
| mcand_i | input | WIDTH (32) | Multiplicand, unsigned |
| mplier_i | input | WIDTH (32) | Multiplier, unsigned |
| hi_o | output | WIDTH (32) | Upper half of the product |
| lo_o | output | WIDTH (32) | Lower half of the product |
| done_o | output | 1 | High when the product is valid |

## Verification
A wrong iteration count or a stuck sequencer shows up at the ports as `done_o` rising one or more edges early or late. The bench samples the two edges on either side of the expected rise. A bad add or shift, a wrong carry out of the adder, or a wrong operand capture only becomes visible when `done_o` rises. At that point the product halves differ from the bench's own full-width multiplication. The all-ones operands stress the carry path on every iteration. Operands that are scrambled right after capture expose any late sampling. Leaving the unit idle after completion shows whether the held result drifts.

// File: rtl/smul_pkg.sv
package smul_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } smul_state_t;

endpackage

// File: rtl/smul_seq.sv
module smul_seq #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic start,
  output logic load_evt,
  output logic step_evt,
  output logic last_step,
  output logic done
);
  import smul_pkg::*;

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

  smul_state_t state_q, state_d;
  logic [CNT_W-1:0] iter_q;

  // Leaving the initialise state happens only on an edge with start low
  assign load_evt  = (state_q == ST_INIT) && !start;
  assign step_evt  = (state_q == ST_RUN);
  assign last_step = step_evt && (iter_q == LAST_IDX);
  assign done      = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT: if (load_evt)  state_d = ST_RUN;
      ST_RUN:  if (last_step) state_d = ST_DONE;
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or posedge start) begin
    if (start) begin
      state_q <= ST_INIT;
      iter_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load_evt)      iter_q <= '0;
      else if (step_evt) iter_q <= iter_q + 1'b1;
    end
  end

endmodule

// File: rtl/smul_acc.sv
module smul_acc #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               load_en,
  input  logic               step_en,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] acc
);

  localparam int PW = 2 * WIDTH;

  // One iteration: add the multiplicand into the upper half when the
  // low bit is set, keep the carry, then shift the whole word right.
  function automatic logic [PW-1:0] add_shift(input logic [PW-1:0] a,
                                               input logic [WIDTH-1:0] m);
    logic [WIDTH:0] upper;
    upper = {1'b0, a[PW-1:WIDTH]} + (a[0] ? {1'b0, m} : '0);
    return {upper, a[WIDTH-1:1]};
  endfunction

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    acc_q;

  // Loaded only when the sequencer leaves its initialise state
  always_ff @(posedge clk) begin
    if (load_en) begin
      mcand_q <= mcand;
      acc_q   <= {{WIDTH{1'b0}}, mplier};
    end else if (step_en) begin
      acc_q   <= add_shift(acc_q, mcand_q);
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/smul_top.sv
module smul_top #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             start,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o,
  output logic             done_o
);

  localparam int PW = 2 * WIDTH;

  logic          load_evt;
  logic          step_evt;
  logic          last_step;
  logic [PW-1:0] acc;

  smul_seq #(.WIDTH(WIDTH)) u_seq (
    .clk       (clk),
    .start     (start),
    .load_evt  (load_evt),
    .step_evt  (step_evt),
    .last_step (last_step),
    .done      (done_o)
  );

  smul_acc #(.WIDTH(WIDTH)) u_acc (
    .clk     (clk),
    .load_en (load_evt),
    .step_en (step_evt),
    .mcand   (mcand_i),
    .mplier  (mplier_i),
    .acc     (acc)
  );

  assign hi_o = acc[PW-1:WIDTH];
  assign lo_o = acc[WIDTH-1:0];

endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             start,
  input logic             load_evt,
  input logic             step_evt,
  input logic             last_step,
  input logic             done_o,
  input logic [WIDTH-1:0] mcand_i,
  input logic [WIDTH-1:0] mplier_i,
  input logic [WIDTH-1:0] hi_o,
  input logic [WIDTH-1:0] lo_o
);

  localparam int NW = $clog2(WIDTH + 1) + 1;
  localparam int PW = 2 * WIDTH;

  logic [NW-1:0]    n_steps;
  logic [WIDTH-1:0] cap_a, cap_b;

  always_ff @(posedge clk or posedge start) begin
    if (start)         n_steps <= '0;
    else if (step_evt) n_steps <= n_steps + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (load_evt) begin
      cap_a <= mcand_i;
      cap_b <= mplier_i;
    end
  end

  // R1
  a_r1_idle_low: assert property (@(posedge clk) start |-> !done_o);

  // R3
  a_r3_iter_count: assert property (@(posedge clk) disable iff (start)
    $rose(done_o) |-> n_steps == NW'(WIDTH));

  // R3
  a_r3_last_then_done: assert property (@(posedge clk) disable iff (start)
    last_step |=> done_o);

  // R3
  a_r3_phase_excl: assert property (@(posedge clk) disable iff (start)
    $onehot0({load_evt, step_evt, done_o}));

  // R2 / R4
  a_r4_product: assert property (@(posedge clk) disable iff (start)
    $rose(done_o) |-> {hi_o, lo_o} == (PW'(cap_a) * PW'(cap_b)));

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (start)
    done_o |=> done_o && $stable(hi_o) && $stable(lo_o));

endmodule

bind smul_top smul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .start     (start),
  .load_evt  (load_evt),
  .step_evt  (step_evt),
  .last_step (last_step),
  .done_o    (done_o),
  .mcand_i   (mcand_i),
  .mplier_i  (mplier_i),
  .hi_o      (hi_o),
  .lo_o      (lo_o)
);

// File: tb/tb_smul_top.sv
`timescale 1ns/1ps
module tb_smul_top;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         start = 1'b1;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic [W-1:0] hi, lo;
  logic         done;

  int n_checks = 0;
  int n_errors = 0;
  int seed_dummy;

  always #5 clk = ~clk;

  smul_top #(.WIDTH(W)) dut (
    .clk(clk), .start(start), .mcand_i(mcand), .mplier_i(mplier),
    .hi_o(hi), .lo_o(lo), .done_o(done)
  );

  // Reference: schoolbook sum of shifted copies, independent of the RTL
  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a,
                                             input logic [W-1:0] b);
    logic [2*W-1:0] s;
    s = '0;
    for (int k = 0; k < W; k++)
      if (b[k]) s = s + ({{W{1'b0}}, a} << k);
    return s;
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // One full run; scramble = change operands right after capture
  task automatic do_run(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit scramble, input string tag);
    logic [2*W-1:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    start = 1'b1;
    mcand = a;
    mplier = b;
    @(negedge clk);
    check("R1 done low while start high", 64'(done), 64'd0);
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);                  // capture edge 0
    @(negedge clk);
    if (scramble) begin
      mcand  = $urandom();
      mplier = $urandom();
    end
    repeat (W - 1) @(posedge clk);   // edge 31
    @(negedge clk);
    check("R3 done low after edge 31", 64'(done), 64'd0);
    @(posedge clk);                  // edge 32
    @(negedge clk);
    check("R3 done high after edge 32", 64'(done), 64'd1);
    check({"R4 full product ", tag}, {hi, lo}, exp);
    check("R8 hi_o upper half", 64'(hi), 64'(exp[2*W-1:W]));
    check("R8 lo_o lower half", 64'(lo), 64'(exp[W-1:0]));
    if (scramble) check("R2 late operand change ignored", {hi, lo}, exp);
    mcand  = ~mcand;
    mplier = mplier + 1;
    repeat (3) @(negedge clk);
    check("R6 done held", 64'(done), 64'd1);
    check("R6 product held", {hi, lo}, exp);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    check("R1 reset state done low", 64'(done), 64'd0);

    // R5 corner cases
    do_run(32'h0000_0000, 32'h1234_5678, 1'b0, "R5 zero a");
    check("R5 zero times value", {hi, lo}, 64'd0);
    do_run(32'hDEAD_BEEF, 32'h0000_0000, 1'b0, "R5 zero b");
    check("R5 value times zero", {hi, lo}, 64'd0);
    do_run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R5 ones");
    check("R5 all ones squared", {hi, lo}, 64'hFFFF_FFFE_0000_0001);
    do_run(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R5 ones by one");
    check("R5 all ones times one", {hi, lo}, 64'h0000_0000_FFFF_FFFF);

    // R7 abandoned run, then a clean run
    @(negedge clk);
    start = 1'b1;
    mcand = 32'h8000_0001;
    mplier = 32'h7FFF_FFFF;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    start = 1'b1;
    #1;
    check("R7 abort forces done low", 64'(done), 64'd0);
    do_run(32'h0001_0003, 32'h0000_FFFF, 1'b0, "R7 after abort");

    // R2 / R4 random runs, half of them scrambled after capture
    for (int n = 0; n < 24; n++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (n % 6 == 0) ra = {ra[31], 31'h7FFF_FFFF};
      do_run(ra, rb, n[0], "random");
    end

    finish_run();
  end

endmodule